// File: doc/BRIEF.md
# Standby Mode Output Controller

This block decides, from a two-bit standby field and an output-disable pin, which parts of an image-sensor signal chain get power. It also decides what every timing output of that chain carries while power is reduced. It enables or disables the analog front end, its reference circuits, the timing core and the master oscillator. It resolves each horizontal clock, the reset gate, the sync pair, the data clock and the data bus to either the live timing-generator value, a fixed safe level, or high impedance. It also picks hold values for the vertical and shutter drivers from two programmed registers. Analog levels and drive currents are represented only by codes.

Three levels of priority apply. The deepest standby wins over the output-disable pin. The output-disable pin wins over the two lighter standby modes. When the deepest standby is left, the timing core is held in reset for a programmable number of master-clock cycles, so that the oscillator has time to settle. A write that enters any standby mode during that wait cancels the wait.

Top module: `stby_out_ctrl`

## Requirements
- R1: The standby field is written through `wr_en`/`wr_data`, and the new value applies from the next clock edge. The codes are 00 run, 01 light standby, 10 medium standby and 11 deep standby, and reset selects deep standby. Power enables by mode: in run, all of `afe_en`, `afe_ref_en`, `tcore_en` and `osc_en` are 1. In light standby, `afe_ref_en`, `tcore_en` and `osc_en` are 1. In medium standby, only `osc_en` is 1. In deep standby, all four are 0.
- R2: `out_ctl` low never changes any power enable.
- R3: In deep standby, whatever `out_ctl` is, `h_oe`, `hl_oe` and `rg_oe` are 0 and all of `h_val`, `hl_val` and `rg_val` are 0. `vd_val`, `hd_val`, `dclk_val` and `data_val` are 0, and `h_drv` is the minimum code 2'b00.
- R4: With `out_ctl` low and no deep standby, H1/H3/HL/RG are driven 0 and H2/H4 are driven 1. `h_val` bit 0 is H1 and bit 3 is H4. `vd_val` and `hd_val` equal `vdhd_pol`, `dclk_val` follows `tg_dclk`, and `data_val` is 0.
- R5: In light or medium standby with `out_ctl` high, the H levels are the same as in R4, `h_drv` is 2'b00, and `vd_val`, `hd_val` and `data_val` are 0. `dclk_val` is live in light standby and 0 in medium standby. Light and medium standby give `h_drv` = 2'b00 whatever `out_ctl` is.
- R6: In run mode with `out_ctl` high, every output follows its `tg_*` input, all H/HL/RG enables are 1, and `h_drv` is the nominal code 2'b11.
- R7: `vd_oe` and `hd_oe` are 0 whenever `slave_mode` is 1 and 1 otherwise, whatever the mode or `out_ctl`.
- R8: Vertical codes are 2 bits per pin (00 low, 01 mid, 10 high), with pin i at `v_code[2i+1:2i]`. In deep standby, pin i is high when `hold_deep[i]` is 1 and low otherwise. `sub_code` is taken from `hold_deep[NUM_V]` in the same way.
- R9: Without deep standby, in light or medium standby or with `out_ctl` low, pin i follows `hold_lite[i]` and `sub_code` follows `tg_sub`. In run mode with `out_ctl` high, pin i follows `tg_v[i]`.
- R10: `vdrv_en` low forces every vertical code to mid (01) and `sub_code` to low (00), over every mode and `out_ctl`.
- R11: `tcore_rst_n` is 0 from reset and whenever deep standby is entered. After a write of 00 while it is held, it rises at exactly the SETTLE_CYC-th clock edge after the write edge. Further 00 writes during that wait do not restart it.
- R12: A write of any nonzero code during the wait cancels it, and `tcore_rst_n` stays 0 until a later 00 write completes a full wait. Writes of 01 or 10 while it is released leave it released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Standby field write strobe |
| wr_data | input | 2 | Standby code to write |
| out_ctl | input | 1 | Output-disable pin, low disables |
| slave_mode | input | 1 | 1 = sync outputs floated |
| vdhd_pol | input | 1 | Sync level when outputs disabled |
| vdrv_en | input | 1 | Vertical driver enable |
| hold_deep | input | NUM_V+1 | Deep standby hold values, top bit shutter |
| hold_lite | input | NUM_V | Vertical hold values for lighter states |
| tg_h | input | 4 | Live H1..H4 |
| tg_hl | input | 1 | Live HL |
| tg_rg | input | 1 | Live reset gate |
| tg_vd | input | 1 | Live vertical sync |
| tg_hd | input | 1 | Live horizontal sync |
| tg_dclk | input | 1 | Live data clock |
| tg_data | input | DATA_W | Live data |
| tg_v | input | NUM_V | Live vertical levels |
| tg_sub | input | 1 | Live shutter level |
| afe_en | output | 1 | Front end enable |
| afe_ref_en | output | 1 | Front end reference enable |
| tcore_en | output | 1 | Timing core enable |
| osc_en | output | 1 | Oscillator enable |
| tcore_rst_n | output | 1 | Timing core reset, active low |
| h_val | output | 4 | H1..H4 value |
| h_oe | output | 4 | H1..H4 output enable |
| hl_val | output | 1 | HL value |
| hl_oe | output | 1 | HL output enable |
| rg_val | output | 1 | Reset gate value |
| rg_oe | output | 1 | Reset gate output enable |
| h_drv | output | 2 | H/RG drive strength code |
| vd_val | output | 1 | Vertical sync value |
| vd_oe | output | 1 | Vertical sync output enable |
| hd_val | output | 1 | Horizontal sync value |
| hd_oe | output | 1 | Horizontal sync output enable |
| dclk_val | output | 1 | Data clock value |
| data_val | output | DATA_W | Data value |
| v_code | output | 2*NUM_V | Vertical level codes |
| sub_code | output | 2 | Shutter level code |

## Verification
A wrong stored standby code shows up in the power enables at the very next clock edge. It also shows up in every resolved pin, because all outputs are combinational from that one register. A settle counter that is off, or not cancelled, shows up only at the moment `tcore_rst_n` rises, which is early, late or missing relative to the write edge. The bench therefore measures that edge exactly and checks every cycle of a cancelled wait. Priority mistakes appear only in particular combinations of mode, `out_ctl`, `slave_mode` and `vdrv_en`, so those combinations are swept together.

// File: rtl/stby_pkg.sv
// Shared codes for the standby output controller.
// Assumes: two-bit vertical level codes and two-bit drive codes.
package stby_pkg;
    typedef enum logic [1:0] {
        MODE_RUN = 2'b00,
        MODE_SB1 = 2'b01,
        MODE_SB2 = 2'b10,
        MODE_SB3 = 2'b11
    } stby_mode_e;

    localparam logic [1:0] VC_LOW  = 2'b00;
    localparam logic [1:0] VC_MID  = 2'b01;
    localparam logic [1:0] VC_HIGH = 2'b10;

    localparam logic [1:0] DRV_MIN = 2'b00;
    localparam logic [1:0] DRV_NOM = 2'b11;
endpackage

// File: rtl/stby_mode_reg.sv
// Holds the standby field. Reset value is deep standby.
// Assumes: a write takes effect at the edge on which wr_en is sampled high.
module stby_mode_reg
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output stby_mode_e mode_q
);
    // Capture a standby write, default to the deepest mode on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_SB3;
        else if (wr_en)
            mode_q <= stby_mode_e'(wr_data);
    end
endmodule

// File: rtl/stby_settle_seq.sv
// Sequences the timing-core reset around deep standby.
// Entering deep standby holds the reset. A 00 write while held starts a
// SETTLE_CYC-cycle wait, and a nonzero write during the wait cancels it.
// Assumes: SETTLE_CYC >= 1.
module stby_settle_seq #(
    parameter int SETTLE_CYC = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic       tcore_rst_n
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic             held_q;
    logic             counting_q;
    logic [CNT_W-1:0] cnt_q;

    logic wr_zero;
    logic wr_nonzero;

    // Classify the current write.
    always_comb begin
        wr_zero    = wr_en && (wr_data == 2'b00);
        wr_nonzero = wr_en && (wr_data != 2'b00);
    end

    // Hold, count and release the timing-core reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q     <= 1'b1;
            counting_q <= 1'b0;
            cnt_q      <= '0;
        end else if (wr_en && wr_data == 2'b11) begin
            held_q     <= 1'b1;
            counting_q <= 1'b0;
            cnt_q      <= '0;
        end else if (wr_nonzero && counting_q) begin
            counting_q <= 1'b0;
            cnt_q      <= '0;
        end else if (counting_q) begin
            if (cnt_q == LAST) begin
                held_q     <= 1'b0;
                counting_q <= 1'b0;
                cnt_q      <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (wr_zero && held_q) begin
            counting_q <= 1'b1;
            cnt_q      <= '0;
        end
    end

    assign tcore_rst_n = !held_q;

    assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_nonzero && counting_q) |=> !tcore_rst_n);
    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        counting_q |-> (cnt_q < CNT_W'(SETTLE_CYC)));
    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tcore_rst_n) |-> $past(counting_q));
endmodule

// File: rtl/stby_pin_mux.sv
// Resolves power enables and the horizontal, sync, data-clock and data pins.
// Priority: deep standby, then out_ctl low, then light/medium standby.
// Assumes: h bit 0 is H1 and bit 3 is H4.
module stby_pin_mux
    import stby_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  stby_mode_e        mode,
    input  logic              out_ctl,
    input  logic              slave_mode,
    input  logic              vdhd_pol,
    input  logic [3:0]        tg_h,
    input  logic              tg_hl,
    input  logic              tg_rg,
    input  logic              tg_vd,
    input  logic              tg_hd,
    input  logic              tg_dclk,
    input  logic [DATA_W-1:0] tg_data,
    output logic              afe_en,
    output logic              afe_ref_en,
    output logic              tcore_en,
    output logic              osc_en,
    output logic [3:0]        h_val,
    output logic [3:0]        h_oe,
    output logic              hl_val,
    output logic              hl_oe,
    output logic              rg_val,
    output logic              rg_oe,
    output logic [1:0]        h_drv,
    output logic              vd_val,
    output logic              vd_oe,
    output logic              hd_val,
    output logic              hd_oe,
    output logic              dclk_val,
    output logic [DATA_W-1:0] data_val
);
    localparam logic [3:0] H_SAFE = 4'b1010;

    logic deep;
    logic lite;

    // Mode decode.
    always_comb begin
        deep = (mode == MODE_SB3);
        lite = (mode == MODE_SB1) || (mode == MODE_SB2);
    end

    // Power enables follow the mode only.
    always_comb begin
        afe_en     = (mode == MODE_RUN);
        afe_ref_en = (mode == MODE_RUN) || (mode == MODE_SB1);
        tcore_en   = (mode == MODE_RUN) || (mode == MODE_SB1);
        osc_en     = !deep;
    end

    // Horizontal clocks and reset gate.
    always_comb begin
        h_drv = (deep || lite) ? DRV_MIN : DRV_NOM;
        if (deep) begin
            h_val = '0; h_oe = '0;
            hl_val = 1'b0; hl_oe = 1'b0;
            rg_val = 1'b0; rg_oe = 1'b0;
        end else if (!out_ctl || lite) begin
            h_val = H_SAFE; h_oe = '1;
            hl_val = 1'b0; hl_oe = 1'b1;
            rg_val = 1'b0; rg_oe = 1'b1;
        end else begin
            h_val = tg_h; h_oe = '1;
            hl_val = tg_hl; hl_oe = 1'b1;
            rg_val = tg_rg; rg_oe = 1'b1;
        end
    end

    // Sync pair, data clock and data bus.
    always_comb begin
        vd_oe = !slave_mode;
        hd_oe = !slave_mode;
        if (deep) begin
            vd_val = 1'b0; hd_val = 1'b0; dclk_val = 1'b0; data_val = '0;
        end else if (!out_ctl) begin
            vd_val = vdhd_pol; hd_val = vdhd_pol; dclk_val = tg_dclk; data_val = '0;
        end else if (lite) begin
            vd_val = 1'b0; hd_val = 1'b0;
            dclk_val = (mode == MODE_SB1) ? tg_dclk : 1'b0;
            data_val = '0;
        end else begin
            vd_val = tg_vd; hd_val = tg_hd; dclk_val = tg_dclk; data_val = tg_data;
        end
    end
endmodule

// File: rtl/stby_vert_hold.sv
// Selects vertical and shutter level codes: live, one of two hold
// registers, or the forced levels used while the vertical driver is off.
// Assumes: hold_deep[NUM_V] is the shutter bit.
module stby_vert_hold
    import stby_pkg::*;
#(
    parameter int NUM_V = 13
) (
    input  stby_mode_e         mode,
    input  logic               out_ctl,
    input  logic               vdrv_en,
    input  logic [NUM_V:0]     hold_deep,
    input  logic [NUM_V-1:0]   hold_lite,
    input  logic [NUM_V-1:0]   tg_v,
    input  logic               tg_sub,
    output logic [2*NUM_V-1:0] v_code,
    output logic [1:0]         sub_code
);
    logic deep;
    logic use_lite;

    // Source selection shared by every vertical pin.
    always_comb begin
        deep     = (mode == MODE_SB3);
        use_lite = !deep && (!out_ctl || mode == MODE_SB1 || mode == MODE_SB2);
    end

    for (genvar i = 0; i < NUM_V; i++) begin : g_vpin
        logic lvl;
        // Pick the level bit for this pin and encode it.
        always_comb begin
            if (deep)          lvl = hold_deep[i];
            else if (use_lite) lvl = hold_lite[i];
            else               lvl = tg_v[i];
            if (!vdrv_en)      v_code[2*i +: 2] = VC_MID;
            else               v_code[2*i +: 2] = lvl ? VC_HIGH : VC_LOW;
        end
    end

    // Shutter level.
    always_comb begin
        if (!vdrv_en) sub_code = VC_LOW;
        else if (deep) sub_code = hold_deep[NUM_V] ? VC_HIGH : VC_LOW;
        else sub_code = tg_sub ? VC_HIGH : VC_LOW;
    end
endmodule

// File: rtl/stby_out_ctrl.sv
// Top of the standby output controller: mode register, timing-core
// reset sequencer, pin resolution and vertical hold selection.
// Assumes: all inputs are synchronous to clk.
module stby_out_ctrl
    import stby_pkg::*;
#(
    parameter int NUM_V      = 13,
    parameter int DATA_W     = 12,
    parameter int SETTLE_CYC = 25000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_data,
    input  logic               out_ctl,
    input  logic               slave_mode,
    input  logic               vdhd_pol,
    input  logic               vdrv_en,
    input  logic [NUM_V:0]     hold_deep,
    input  logic [NUM_V-1:0]   hold_lite,
    input  logic [3:0]         tg_h,
    input  logic               tg_hl,
    input  logic               tg_rg,
    input  logic               tg_vd,
    input  logic               tg_hd,
    input  logic               tg_dclk,
    input  logic [DATA_W-1:0]  tg_data,
    input  logic [NUM_V-1:0]   tg_v,
    input  logic               tg_sub,
    output logic               afe_en,
    output logic               afe_ref_en,
    output logic               tcore_en,
    output logic               osc_en,
    output logic               tcore_rst_n,
    output logic [3:0]         h_val,
    output logic [3:0]         h_oe,
    output logic               hl_val,
    output logic               hl_oe,
    output logic               rg_val,
    output logic               rg_oe,
    output logic [1:0]         h_drv,
    output logic               vd_val,
    output logic               vd_oe,
    output logic               hd_val,
    output logic               hd_oe,
    output logic               dclk_val,
    output logic [DATA_W-1:0]  data_val,
    output logic [2*NUM_V-1:0] v_code,
    output logic [1:0]         sub_code
);
    stby_mode_e mode_q;

    stby_mode_reg i_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode_q(mode_q)
    );

    stby_settle_seq #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tcore_rst_n(tcore_rst_n)
    );

    stby_pin_mux #(.DATA_W(DATA_W)) i_pins (
        .mode(mode_q), .out_ctl(out_ctl), .slave_mode(slave_mode),
        .vdhd_pol(vdhd_pol), .tg_h(tg_h), .tg_hl(tg_hl), .tg_rg(tg_rg),
        .tg_vd(tg_vd), .tg_hd(tg_hd), .tg_dclk(tg_dclk), .tg_data(tg_data),
        .afe_en(afe_en), .afe_ref_en(afe_ref_en), .tcore_en(tcore_en),
        .osc_en(osc_en), .h_val(h_val), .h_oe(h_oe), .hl_val(hl_val),
        .hl_oe(hl_oe), .rg_val(rg_val), .rg_oe(rg_oe), .h_drv(h_drv),
        .vd_val(vd_val), .vd_oe(vd_oe), .hd_val(hd_val), .hd_oe(hd_oe),
        .dclk_val(dclk_val), .data_val(data_val)
    );

    stby_vert_hold #(.NUM_V(NUM_V)) i_vert (
        .mode(mode_q), .out_ctl(out_ctl), .vdrv_en(vdrv_en),
        .hold_deep(hold_deep), .hold_lite(hold_lite), .tg_v(tg_v),
        .tg_sub(tg_sub), .v_code(v_code), .sub_code(sub_code)
    );

    assert_deep_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SB3) |-> (h_oe == 4'b0000 && !hl_oe && !rg_oe && data_val == '0));
    assert_lite_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SB1 || mode_q == MODE_SB2) |-> (h_drv == DRV_MIN));
    assert_slave_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (!vd_oe && !hd_oe));
    assert_vdrv_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vdrv_en |-> (v_code == {NUM_V{VC_MID}} && sub_code == VC_LOW));
    assert_deep_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SB3) |-> !tcore_rst_n);
    assert_oscoff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en) |-> (!tcore_en && !afe_ref_en));
endmodule

// File: tb/test_stby_out_ctrl.sv
module test_stby_out_ctrl;
    localparam int NV = 13;
    localparam int DW = 12;
    localparam int SETTLE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic out_ctl = 1'b1, slave_mode = 1'b0, vdhd_pol = 1'b0, vdrv_en = 1'b1;
    logic [NV:0] hold_deep = '0;
    logic [NV-1:0] hold_lite = '0;
    logic [3:0] tg_h = '0;
    logic tg_hl = 0, tg_rg = 0, tg_vd = 0, tg_hd = 0, tg_dclk = 0, tg_sub = 0;
    logic [DW-1:0] tg_data = '0;
    logic [NV-1:0] tg_v = '0;

    logic afe_en, afe_ref_en, tcore_en, osc_en, tcore_rst_n;
    logic [3:0] h_val, h_oe;
    logic hl_val, hl_oe, rg_val, rg_oe, vd_val, vd_oe, hd_val, hd_oe, dclk_val;
    logic [1:0] h_drv, sub_code;
    logic [DW-1:0] data_val;
    logic [2*NV-1:0] v_code;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // Reference model state.
    int m_mode = 3;
    bit m_held = 1;
    int m_left = -1;
    bit m_aborted = 0;

    always #10 clk = ~clk;

    stby_out_ctrl #(.NUM_V(NV), .DATA_W(DW), .SETTLE_CYC(SETTLE)) i_stby_out_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .out_ctl(out_ctl), .slave_mode(slave_mode), .vdhd_pol(vdhd_pol),
        .vdrv_en(vdrv_en), .hold_deep(hold_deep), .hold_lite(hold_lite),
        .tg_h(tg_h), .tg_hl(tg_hl), .tg_rg(tg_rg), .tg_vd(tg_vd), .tg_hd(tg_hd),
        .tg_dclk(tg_dclk), .tg_data(tg_data), .tg_v(tg_v), .tg_sub(tg_sub),
        .afe_en(afe_en), .afe_ref_en(afe_ref_en), .tcore_en(tcore_en),
        .osc_en(osc_en), .tcore_rst_n(tcore_rst_n), .h_val(h_val), .h_oe(h_oe),
        .hl_val(hl_val), .hl_oe(hl_oe), .rg_val(rg_val), .rg_oe(rg_oe),
        .h_drv(h_drv), .vd_val(vd_val), .vd_oe(vd_oe), .hd_val(hd_val),
        .hd_oe(hd_oe), .dclk_val(dclk_val), .data_val(data_val),
        .v_code(v_code), .sub_code(sub_code)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model update on every edge, from the written requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 3; m_held = 1; m_left = -1; m_aborted = 0;
        end else begin
            if (wr_en && wr_data == 2'b11) begin
                m_held = 1; m_left = -1;
            end else if (wr_en && wr_data != 2'b00 && m_left >= 0) begin
                m_left = -1; m_aborted = 1;
            end else if (m_left >= 0) begin
                if (m_left == 0) begin m_held = 0; m_left = -1; end
                else m_left--;
            end else if (wr_en && wr_data == 2'b00 && m_held) begin
                m_left = SETTLE - 1;
            end
            if (wr_en) m_mode = wr_data;
            started = 1;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        #3;
        if (started && rst_n && !done) begin
            bit deep, lite, ol;
            string dreq, preq, vreq;
            logic [3:0] eh;
            logic [2*NV-1:0] ev;
            logic [1:0] es;
            deep = (m_mode == 3);
            lite = (m_mode == 1 || m_mode == 2);
            ol = !out_ctl;
            dreq = deep ? "R3" : ol ? "R4" : lite ? "R5" : "R6";
            preq = ol ? "R2" : "R1";
            chk(preq, "afe_en", afe_en, m_mode == 0);
            chk(preq, "afe_ref_en", afe_ref_en, m_mode <= 1);
            chk(preq, "tcore_en", tcore_en, m_mode <= 1);
            chk(preq, "osc_en", osc_en, !deep);
            eh = deep ? 4'b0000 : (ol || lite) ? 4'b1010 : tg_h;
            chk(dreq, "h_val", h_val, eh);
            chk(dreq, "h_oe", h_oe, deep ? 4'h0 : 4'hF);
            chk(dreq, "hl", {hl_val, hl_oe}, {(!deep && !ol && !lite) ? tg_hl : 1'b0, !deep});
            chk(dreq, "rg", {rg_val, rg_oe}, {(!deep && !ol && !lite) ? tg_rg : 1'b0, !deep});
            chk(lite ? "R5" : dreq, "h_drv", h_drv, (deep || lite) ? 2'b00 : 2'b11);
            chk("R7", "sync_oe", {vd_oe, hd_oe}, slave_mode ? 2'b00 : 2'b11);
            chk(dreq, "vd_val", vd_val, deep ? 1'b0 : ol ? vdhd_pol : lite ? 1'b0 : tg_vd);
            chk(dreq, "hd_val", hd_val, deep ? 1'b0 : ol ? vdhd_pol : lite ? 1'b0 : tg_hd);
            chk(dreq, "dclk_val", dclk_val, deep ? 1'b0 : ol ? tg_dclk : (m_mode == 2) ? 1'b0 : tg_dclk);
            chk(dreq, "data_val", data_val, (deep || ol || lite) ? '0 : tg_data);
            for (int i = 0; i < NV; i++) begin
                bit b;
                b = deep ? hold_deep[i] : (ol || lite) ? hold_lite[i] : tg_v[i];
                ev[2*i +: 2] = !vdrv_en ? 2'b01 : b ? 2'b10 : 2'b00;
            end
            es = !vdrv_en ? 2'b00 : (deep ? hold_deep[NV] : tg_sub) ? 2'b10 : 2'b00;
            vreq = !vdrv_en ? "R10" : deep ? "R8" : (ol || lite) ? "R9" : "R6";
            chk(vreq, "v_code", v_code, ev);
            chk(vreq, "sub_code", sub_code, es);
            chk(m_aborted ? "R12" : "R11", "tcore_rst_n", tcore_rst_n, !m_held);
        end
    end

    task automatic randomize_live();
        tg_h = 4'($urandom); tg_hl = 1'($urandom); tg_rg = 1'($urandom);
        tg_vd = 1'($urandom); tg_hd = 1'($urandom); tg_dclk = 1'($urandom);
        tg_data = DW'($urandom); tg_v = NV'($urandom); tg_sub = 1'($urandom);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            randomize_live();
        end
    endtask

    task automatic wr(input logic [1:0] d);
        @(negedge clk);
        randomize_live();
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        randomize_live();
        wr_en = 1'b0;
    endtask

    // Count edges from a 00 write to the reset release (R11).
    task automatic measure_release(input int expect_cyc);
        int n;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 2'b00;
        @(posedge clk);
        n = 0;
        @(negedge clk);
        wr_en = 1'b0;
        while (!tcore_rst_n && n < expect_cyc + 5) begin
            @(posedge clk); n++;
            #1;
        end
        chk("R11", "release edge count", n, expect_cyc);
    endtask

    initial begin
        hold_deep = {1'b1, 13'h0A5C};
        hold_lite = 13'h1363;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1 reset state: deep standby, core held.
        chk("R1", "reset osc_en", osc_en, 0);
        chk("R11", "reset tcore_rst_n", tcore_rst_n, 0);
        step(4);
        out_ctl = 1'b0; step(4); out_ctl = 1'b1;          // R3 priority over out_ctl
        measure_release(SETTLE);                           // R11 exact wait
        step(8);
        out_ctl = 1'b0; vdhd_pol = 1'b1; step(8);          // R4, R2
        vdhd_pol = 1'b0; step(4); out_ctl = 1'b1;
        wr(2'b01); step(8); out_ctl = 1'b0; step(4); out_ctl = 1'b1;   // R5, R9
        wr(2'b10); step(8); slave_mode = 1'b1; step(6);               // R7
        vdrv_en = 1'b0; step(6); vdrv_en = 1'b1;                      // R10
        wr(2'b00); step(4); slave_mode = 1'b0;
        chk("R12", "light write keeps release", tcore_rst_n, 1);
        wr(2'b11); vdrv_en = 1'b0; step(4); vdrv_en = 1'b1; step(4);  // R8
        wr(2'b00); step(5); wr(2'b01);                                // R12 abort
        step(SETTLE + 5);
        chk("R12", "aborted stays in reset", tcore_rst_n, 0);
        wr(2'b00); step(3); wr(2'b00); step(SETTLE);                  // R11 no restart
        chk("R11", "released after second 00", tcore_rst_n, 1);
        wr(2'b11); wr(2'b00); step(4); wr(2'b11); step(SETTLE + 3);
        chk("R12", "deep write aborts", tcore_rst_n, 0);
        // Mixed sweep of all controls.
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            randomize_live();
            out_ctl = ($urandom % 4) != 0;
            slave_mode = 1'($urandom);
            vdhd_pol = 1'($urandom);
            vdrv_en = ($urandom % 5) != 0;
            if (($urandom % 8) == 0) hold_deep = (NV+1)'($urandom);
            if (($urandom % 8) == 0) hold_lite = NV'($urandom);
            wr_en = ($urandom % 12) == 0;
            wr_data = 2'($urandom);
            if (wr_en && wr_data == 2'b11 && ($urandom % 2) == 0) wr_data = 2'b00;
        end
        @(negedge clk); wr_en = 1'b0;
        step(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule